// File: doc/BRIEF.md
# Queued Interrupt Controller

This block holds the interrupt state of a small 16-bit processor core. It keeps the handler address register, a first-in first-out store of pending 16-bit interrupt messages, and a flag that holds delivery back. Interrupts are never ranked against each other. Software and hardware requests are appended to the store in arrival order. When a software and a hardware request arrive in the same cycle, the software message goes in first.

At each instruction boundary the controller takes at most one message from the head of the store. If the handler address is nonzero when the message leaves the store, the controller hands the message to the core over a valid/ready output and turns the hold flag on. The core then pushes PC and then A, sets PC to the handler address and sets A to the message. If the handler address is zero at that moment, the message is dropped without effect. The hold flag is cleared by the return-from-interrupt strobe. The queue-control strobe sets or clears the flag from its operand.

The valid/ready rules are these. Once `dlv_valid` rises, `dlv_msg` stays fixed and `dlv_valid` stays high until a cycle in which `dlv_ready` is high. No further message leaves the store while a delivery is waiting. If a push finds the store full, that push is refused and a sticky fault flag is raised. `DEPTH` must be a power of two.

Top module: `irq_queue_ctrl`

## Requirements
- R1: After reset, `dlv_valid` is 0, `fault` is 0, `ia_value` is 0 and the hold flag is off.
- R2: A cycle with `ias_we` high loads `ias_val` into the handler address, and `ia_value` shows the new value from the next cycle.
- R3: A message leaves the store only in a cycle with `boundary` high. At most one message leaves per boundary, and messages leave in arrival order.
- R4: A delivered message raises `dlv_valid` one cycle after the boundary, with `dlv_msg` equal to the message. Both are held unchanged until `dlv_ready` is high, and the delivery turns the hold flag on.
- R5: While the hold flag is on, the store still accepts requests, but no message leaves it on a boundary.
- R6: A cycle with `rfi` high turns the hold flag off, so the next boundary delivers the next stored message.
- R7: A cycle with `iaq_we` high turns the hold flag on when `iaq_val` is nonzero and off when it is zero.
- R8: The handler address is tested when a message leaves the store. If it is zero at that moment, the message is removed, `dlv_valid` stays 0 and the hold flag is unchanged.
- R9: A software request and a hardware request in the same cycle are both stored, with the software message ahead of the hardware message.
- R10: A push that finds `DEPTH` messages already stored is refused and sets `fault`. `fault` then stays 1 until reset, and the stored messages are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw_req | input | 1 | Software interrupt request |
| sw_msg | input | MSG_W | Software interrupt message |
| hw_req | input | 1 | Hardware interrupt request |
| hw_msg | input | MSG_W | Hardware interrupt message |
| ias_we | input | 1 | Load the handler address |
| ias_val | input | MSG_W | New handler address |
| iaq_we | input | 1 | Queue-control strobe |
| iaq_val | input | MSG_W | Queue-control operand; nonzero turns the hold on |
| rfi | input | 1 | Return from interrupt; turns the hold off |
| boundary | input | 1 | Instruction-boundary pulse |
| dlv_valid | output | 1 | Delivery request to the core |
| dlv_ready | input | 1 | Core accepts the delivery |
| dlv_msg | output | MSG_W | Message to load into A |
| ia_value | output | MSG_W | Current handler address |
| fault | output | 1 | Sticky store-overflow fault |

## Verification
Each wrong internal state in this block shows at the ports within one or two cycles of the next boundary.

- A corrupted write or read pointer delivers a message out of order, and the scoreboard compares every handshake against the arrival order.
- A hold flag stuck on makes an expected delivery go missing.
- A hold flag stuck off makes a delivery appear one cycle after a boundary where none was expected.
- A wrong occupancy count shows either as an early fault or as a missing fault on the push after the store fills. The bench checks both sides of that edge.

// File: rtl/irqq_pkg.sv
package irqq_pkg;
  localparam int unsigned DEF_MSG_W = 16;
  localparam int unsigned DEF_DEPTH = 256;

  typedef struct packed {
    logic vld;
    logic [DEF_MSG_W-1:0] msg;
  } irq_word_t;
endpackage

// File: rtl/irqq_store.sv
module irqq_store #(
  parameter int unsigned MSG_W = 16,
  parameter int unsigned DEPTH = 256
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_a,
  input  logic [MSG_W-1:0] data_a,
  input  logic             push_b,
  input  logic [MSG_W-1:0] data_b,
  input  logic             pop,
  output logic [MSG_W-1:0] head,
  output logic             empty,
  output logic             drop
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [MSG_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    count;
  logic [CW:0]      room;
  logic             acc1, acc2;
  logic [1:0]       n_in;
  logic [MSG_W-1:0] d0, d1;

  // the a-side request is ordered ahead of the b-side one
  assign d0   = push_a ? data_a : data_b;
  assign d1   = data_b;
  assign room = (CW+1)'(DEPTH) - {1'b0, count} + {{CW{1'b0}}, pop};
  assign acc1 = (push_a | push_b) && (room >= (CW+1)'(1));
  assign acc2 = (push_a & push_b) && (room >= (CW+1)'(2));
  assign n_in = {1'b0, acc1} + {1'b0, acc2};
  assign drop = ((push_a | push_b) & ~acc1) | ((push_a & push_b) & ~acc2);
  assign head  = mem[rp];
  assign empty = (count == '0);

  always_ff @(posedge clk) begin
    if (acc1) mem[wp] <= d0;
    if (acc2) mem[wp + AW'(1)] <= d1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= wp + AW'(n_in);
      if (pop) rp <= rp + AW'(1);
      count <= count + CW'(n_in) - CW'(pop);
    end
  end
endmodule

// File: rtl/irqq_ctl.sv
module irqq_ctl #(
  parameter int unsigned MSG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ias_we,
  input  logic [MSG_W-1:0] ias_val,
  input  logic             iaq_we,
  input  logic [MSG_W-1:0] iaq_val,
  input  logic             rfi,
  input  logic             boundary,
  input  logic             store_empty,
  input  logic             stage_busy,
  output logic [MSG_W-1:0] ia_q,
  output logic             q_on,
  output logic             pop,
  output logic             deliver
);
  assign pop     = boundary && !q_on && !stage_busy && !store_empty;
  assign deliver = pop && (ia_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ia_q <= '0;
      q_on <= 1'b0;
    end else begin
      if (ias_we) ia_q <= ias_val;
      if (deliver)     q_on <= 1'b1;
      else if (rfi)    q_on <= 1'b0;
      else if (iaq_we) q_on <= (iaq_val != '0);
    end
  end
endmodule

// File: rtl/irqq_stage.sv
module irqq_stage #(
  parameter int unsigned MSG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [MSG_W-1:0] load_msg,
  input  logic             ready,
  output logic             valid,
  output logic [MSG_W-1:0] msg
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      msg   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      msg   <= load_msg;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_queue_ctrl.sv
module irq_queue_ctrl #(
  parameter int unsigned MSG_W = irqq_pkg::DEF_MSG_W,
  parameter int unsigned DEPTH = irqq_pkg::DEF_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_req,
  input  logic [MSG_W-1:0] sw_msg,
  input  logic             hw_req,
  input  logic [MSG_W-1:0] hw_msg,
  input  logic             ias_we,
  input  logic [MSG_W-1:0] ias_val,
  input  logic             iaq_we,
  input  logic [MSG_W-1:0] iaq_val,
  input  logic             rfi,
  input  logic             boundary,
  output logic             dlv_valid,
  input  logic             dlv_ready,
  output logic [MSG_W-1:0] dlv_msg,
  output logic [MSG_W-1:0] ia_value,
  output logic             fault
);
  logic [MSG_W-1:0] head;
  logic empty, drop, pop, deliver, q_on;

  irqq_store #(.MSG_W(MSG_W), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push_a(sw_req), .data_a(sw_msg),
    .push_b(hw_req), .data_b(hw_msg),
    .pop(pop), .head(head), .empty(empty), .drop(drop)
  );

  irqq_ctl #(.MSG_W(MSG_W)) u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ias_we(ias_we), .ias_val(ias_val),
    .iaq_we(iaq_we), .iaq_val(iaq_val),
    .rfi(rfi), .boundary(boundary),
    .store_empty(empty), .stage_busy(dlv_valid),
    .ia_q(ia_value), .q_on(q_on), .pop(pop), .deliver(deliver)
  );

  irqq_stage #(.MSG_W(MSG_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .load(deliver), .load_msg(head), .ready(dlv_ready),
    .valid(dlv_valid), .msg(dlv_msg)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) fault <= 1'b0;
    else if (drop) fault <= 1'b1;
  end
endmodule

// File: rtl/irqq_checker.sv
module irqq_checker #(
  parameter int unsigned MSG_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             boundary,
  input logic             ias_we,
  input logic [MSG_W-1:0] ias_val,
  input logic             dlv_valid,
  input logic             dlv_ready,
  input logic [MSG_W-1:0] dlv_msg,
  input logic [MSG_W-1:0] ia_value,
  input logic             fault,
  input logic             q_on
);
  AST_HOLD_UNTIL_READY: assert property (@(posedge clk) disable iff (!rst_n)
    dlv_valid && !dlv_ready |=> dlv_valid && $stable(dlv_msg)); // R4
  AST_RISE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlv_valid) |-> $past(boundary)); // R3
  AST_NO_DEQUEUE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    q_on |=> !$rose(dlv_valid)); // R5
  AST_ZERO_IA_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dlv_valid) |-> $past(ia_value) != '0); // R8
  AST_IA_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ias_we |=> ia_value == $past(ias_val)); // R2
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> fault); // R10
endmodule

bind irq_queue_ctrl irqq_checker #(.MSG_W(MSG_W)) u_irqq_checker (
  .clk(clk), .rst_n(rst_n), .boundary(boundary),
  .ias_we(ias_we), .ias_val(ias_val),
  .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_msg(dlv_msg),
  .ia_value(ia_value), .fault(fault), .q_on(q_on)
);

// File: tb/irq_queue_ctrl_bench.sv
module irq_queue_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int MSG_W = 16;
  localparam int DEPTH = 256;

  logic clk = 0, rst_n = 0;
  logic sw_req = 0, hw_req = 0, ias_we = 0, iaq_we = 0, rfi = 0, boundary = 0;
  logic dlv_ready = 1;
  logic [MSG_W-1:0] sw_msg = '0, hw_msg = '0, ias_val = '0, iaq_val = '0;
  logic dlv_valid, fault;
  logic [MSG_W-1:0] dlv_msg, ia_value;

  int total = 0, failed = 0;
  bit finished = 0;
  logic [MSG_W-1:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_queue_ctrl #(.MSG_W(MSG_W), .DEPTH(DEPTH)) u_irq_queue_ctrl (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_msg(sw_msg),
    .hw_req(hw_req), .hw_msg(hw_msg), .ias_we(ias_we), .ias_val(ias_val),
    .iaq_we(iaq_we), .iaq_val(iaq_val), .rfi(rfi), .boundary(boundary),
    .dlv_valid(dlv_valid), .dlv_ready(dlv_ready), .dlv_msg(dlv_msg),
    .ia_value(ia_value), .fault(fault)
  );

  task automatic check(string req, logic [MSG_W-1:0] act, logic [MSG_W-1:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every handshake is compared against the scoreboard (R3, R4)
  always begin
    @(negedge clk); #1;
    if (rst_n && dlv_valid && dlv_ready) begin
      if (exp_q.size() == 0) check("R3 unexpected delivery", dlv_msg, 16'hxxxx);
      else check("R3 delivery order", dlv_msg, exp_q.pop_front());
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic push(logic s, logic [MSG_W-1:0] sm, logic h, logic [MSG_W-1:0] hm);
    sw_req = s; sw_msg = sm; hw_req = h; hw_msg = hm; tick(); sw_req = 0; hw_req = 0;
  endtask
  task automatic pulse_boundary(); boundary = 1; tick(); boundary = 0; endtask
  task automatic pulse_rfi(); rfi = 1; tick(); rfi = 0; endtask
  task automatic set_ia(logic [MSG_W-1:0] v); ias_we = 1; ias_val = v; tick(); ias_we = 0; endtask
  task automatic set_iaq(logic [MSG_W-1:0] v); iaq_we = 1; iaq_val = v; tick(); iaq_we = 0; endtask
  task automatic deliver(logic [MSG_W-1:0] m); exp_q.push_back(m); pulse_boundary(); tick(); tick(); endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    total++; failed++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_n = 1; #1;
    check("R1 valid", 16'(dlv_valid), 16'h0);
    check("R1 fault", 16'(fault), 16'h0);
    check("R1 ia", ia_value, 16'h0);
    tick();
    set_ia(16'h1234); #1;
    check("R2 ia load", ia_value, 16'h1234);

    // R1 hold flag off after reset: one stored message delivered on boundary
    push(1, 16'h00A1, 0, '0);
    tick(); tick(); #1;
    check("R3 no boundary no delivery", 16'(dlv_valid), 16'h0);
    deliver(16'h00A1);

    // R9 and R5: both requests stored, nothing leaves while held
    push(1, 16'h00B2, 1, 16'h00C3);
    pulse_boundary(); pulse_boundary(); #1;
    check("R5 held no delivery", 16'(dlv_valid), 16'h0);
    pulse_rfi();
    deliver(16'h00B2);  // R6, R9 software first
    pulse_rfi();
    deliver(16'h00C3);  // R9

    // R7
    pulse_rfi();
    set_iaq(16'h0001);
    push(1, 16'h00D4, 0, '0);
    pulse_boundary(); #1;
    check("R7 iaq nonzero holds", 16'(dlv_valid), 16'h0);
    tick();
    set_iaq(16'h0000);
    deliver(16'h00D4);
    pulse_rfi();

    // R4 hold until ready
    dlv_ready = 0;
    push(1, 16'h00E5, 0, '0);
    exp_q.push_back(16'h00E5);
    pulse_boundary();
    for (int k = 0; k < 3; k++) begin
      #1;
      check("R4 valid held", 16'(dlv_valid), 16'h1);
      check("R4 msg held", dlv_msg, 16'h00E5);
      tick();
    end
    dlv_ready = 1;
    tick(); tick();
    pulse_rfi();

    // R8 zero IA at dequeue discards
    set_iaq(16'h0001);
    push(1, 16'h00F6, 0, '0);
    set_ia(16'h0000);
    set_iaq(16'h0000);
    pulse_boundary(); #1;
    check("R8 zero ia no delivery", 16'(dlv_valid), 16'h0);
    tick();
    set_ia(16'h2000);
    pulse_boundary(); #1;
    check("R8 entry removed", 16'(dlv_valid), 16'h0);
    tick();
    push(0, '0, 1, 16'h0077);
    deliver(16'h0077);
    pulse_rfi();

    // R10 overflow
    set_iaq(16'h0001);
    for (int i = 0; i < DEPTH/2; i++)
      push(1, 16'(16'h1000 + 2*i), 1, 16'(16'h1001 + 2*i));
    #1;
    check("R10 full no fault", 16'(fault), 16'h0);
    push(1, 16'hDEAD, 0, '0); #1;
    check("R10 overflow fault", 16'(fault), 16'h1);
    set_iaq(16'h0000);
    deliver(16'h1000);
    pulse_rfi();
    deliver(16'h1001);
    #1;
    check("R10 fault sticky", 16'(fault), 16'h1);
    check("R3 scoreboard drained", 16'(exp_q.size()), 16'h0);
    finish_run();
  end
endmodule